// File: doc/BRIEF.md
# Watchdog Timer with Reset Pulse Generator

This block supervises software liveness by watching a single kick line. Every change of level on the kick line, rising or falling, restarts a timeout counter. If the counter runs out with no change on the kick line, an active-low fault output drops and stays down. A fault clears only when the kick line moves again or when a reset releases it. A reset pulse generator is built into the same block. It produces an active-low system reset for a fixed number of cycles after power-on and after any cycle in which the active-low manual-reset input is seen low. The manual-reset input is level sensitive and passes through a synchroniser first.

A strap input can route the fault back into the reset generator. When the strap is set, a fault starts a system reset. A short, fixed number of cycles after the reset asserts, the fault releases, so the fault line gives a narrow pulse that other logic can capture. If the kick line is stuck in this mode, reset pulses repeat with a constant period.

While reset is active the timeout counter is held at zero. The fault output is then driven from the supply-above-switchover flag: high when the flag is set and no fault is pending, and low when the flag is clear. The watchdog has no enable and cannot be turned off. All durations are parameters counted in clock cycles.

Top module: `wdt_supervisor`

## Requirements
- R1: While the power-on reset input is low, sysRstN is 0 and wdoN is 1 (with supplyHi = 1). After power-on reset releases, sysRstN stays 0 for RST_CYC to RST_CYC+2 cycles.
- R2: After manRstN goes low, sysRstN goes to 0 within 4 cycles. After manRstN returns high, sysRstN stays 0 for RST_CYC to RST_CYC+4 cycles.
- R3: While reset is active the timeout counter is held cleared. A reset longer than TIMEOUT_CYC raises no fault. After reset releases with no kick, wdoN falls TIMEOUT_CYC to TIMEOUT_CYC+5 cycles later.
- R4: With no kick transition, wdoN falls to 0 between TIMEOUT_CYC and TIMEOUT_CYC+5 cycles after the last transition.
- R5: Rising and falling kick transitions both restart the timeout. A transition within TIMEOUT_CYC cycles of the previous one keeps wdoN at 1.
- R6: A kick pulse that lasts one clock cycle is detected and restarts the timeout.
- R7: With loopEn = 0, a fault holds wdoN at 0 and sysRstN at 1 until a kick transition. After that transition, wdoN returns to 1 within 5 cycles.
- R8: While reset is active, wdoN is 0 when supplyHi = 0. It is 1 when supplyHi = 1 and no fault is pending.
- R9: With loopEn = 1, a fault asserts sysRstN = 0. wdoN stays low for CLR_CYC to CLR_CYC+3 cycles and returns to 1 while sysRstN is still 0.
- R10: With loopEn = 1 and the kick line held constant, reset pulses repeat with a constant period. The period is between RST_CYC+TIMEOUT_CYC and RST_CYC+TIMEOUT_CYC+CLR_CYC+8 cycles. Each pulse lasts RST_CYC to RST_CYC+CLR_CYC+4 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| kickIn | input | 1 | Watchdog kick line, asynchronous; any level change restarts the timeout |
| manRstN | input | 1 | Manual reset request, active low, level sensitive, asynchronous |
| supplyHi | input | 1 | Supply above switchover; sets the level of wdoN during reset |
| loopEn | input | 1 | Strap: route the fault into the reset generator |
| sysRstN | output | 1 | System reset, active low |
| wdoN | output | 1 | Watchdog fault, active low |

## Verification
A timeout counter that is not cleared shows up as a wdoN fall earlier than TIMEOUT_CYC after a kick. This is visible within a single timeout window. A missed edge polarity makes every other table entry fault. A stuck fault latch or a wrong release point in loopback mode changes the width of the wdoN pulse, the reset length or the repeat period. Each of these appears at the ports within one period of a few tens of cycles. A supply-flag decode error shows on wdoN in the same cycle the flag changes during reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadRst;   // (re)start the reset pulse counter
    logic clrWd;     // clear the timeout counter
  } wdtStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic kickEdge;   // a synchronised kick transition this cycle
    logic mrLow;      // synchronised manual reset is low
    logic rstActive;  // system reset currently asserted
    logic ageDone;    // reset has been active for the clear delay
    logic timeoutHit; // timeout counter at its limit
  } wdtStatus_t;

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RST_VAL}};
    else       pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1600000,
  parameter int RST_CYC     = 200000,
  parameter int CLR_CYC     = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       kickIn,
  input  logic       manRstN,
  input  wdtStrobe_t strobe,
  output wdtStatus_t status
);

  localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);
  localparam int RST_W = $clog2(RST_CYC + 1);
  localparam int CLR_W = $clog2(CLR_CYC + 1);
  localparam logic [TO_W-1:0]  TO_LIMIT  = TO_W'(TIMEOUT_CYC);
  localparam logic [RST_W-1:0] RST_LOAD  = RST_W'(RST_CYC);
  localparam logic [CLR_W-1:0] CLR_LIMIT = CLR_W'(CLR_CYC);

  logic kickSync, kickPrev, mrSyncN;
  logic [TO_W-1:0]  wdCnt;
  logic [RST_W-1:0] rstCnt;
  logic [CLR_W-1:0] rstAge;

  wdt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_kickSync (
    .clk(clk), .rstN(rstN), .d(kickIn), .q(kickSync)
  );

  wdt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_mrSync (
    .clk(clk), .rstN(rstN), .d(manRstN), .q(mrSyncN)
  );

  // Edge detect on either polarity
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) kickPrev <= 1'b0;
    else       kickPrev <= kickSync;
  end

  // Reset pulse counter: power-on starts a full pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rstCnt <= RST_LOAD;
    else if (strobe.loadRst)  rstCnt <= RST_LOAD;
    else if (rstCnt != '0)    rstCnt <= rstCnt - 1'b1;
  end

  // Cycles since reset assertion, saturating at the clear delay
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   rstAge <= '0;
    else if (rstCnt == '0)       rstAge <= '0;
    else if (rstAge != CLR_LIMIT) rstAge <= rstAge + 1'b1;
  end

  // Timeout counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  wdCnt <= '0;
    else if (strobe.clrWd)      wdCnt <= '0;
    else if (wdCnt != TO_LIMIT) wdCnt <= wdCnt + 1'b1;
  end

  always_comb begin
    status.kickEdge   = kickSync ^ kickPrev;
    status.mrLow      = ~mrSyncN;
    status.rstActive  = (rstCnt != '0);
    status.ageDone    = (rstAge == CLR_LIMIT);
    status.timeoutHit = (wdCnt == TO_LIMIT);
  end

  assert_load_asserts_rst_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadRst |=> status.rstActive);

  assert_rst_counts_down_R2: assert property (@(posedge clk) disable iff (!rstN)
    (status.rstActive && !strobe.loadRst) |=> (rstCnt == $past(rstCnt) - 1'b1));

  assert_held_clear_in_rst_R3: assert property (@(posedge clk) disable iff (!rstN)
    status.rstActive |=> (wdCnt == '0));

  assert_edge_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    status.kickEdge |=> (wdCnt == '0));

endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loopEn,
  input  logic       supplyHi,
  input  wdtStatus_t status,
  output wdtStrobe_t strobe,
  output logic       sysRstN,
  output logic       wdoN
);

  logic faultQ;

  // Fault latch: set on timeout outside reset, released by a kick
  // or once reset has been active for the clear delay
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                    faultQ <= 1'b0;
    else if (status.rstActive && status.ageDone)  faultQ <= 1'b0;
    else if (status.kickEdge)                     faultQ <= 1'b0;
    else if (status.timeoutHit && !status.rstActive) faultQ <= 1'b1;
  end

  always_comb begin
    strobe.loadRst = status.mrLow | (loopEn & faultQ);
    strobe.clrWd   = status.rstActive | status.kickEdge;
    sysRstN        = ~status.rstActive;
    wdoN           = (status.rstActive && !supplyHi) ? 1'b0 : ~faultQ;
  end

  assert_fault_after_timeout_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultQ) |-> $past(status.timeoutHit));

  assert_fault_release_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultQ) |-> ($past(status.kickEdge) || $past(status.ageDone)));

  assert_loop_fault_resets_R9: assert property (@(posedge clk) disable iff (!rstN)
    (faultQ && loopEn) |=> status.rstActive);

  assert_mr_resets_R2: assert property (@(posedge clk) disable iff (!rstN)
    status.mrLow |=> !sysRstN);

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
  import wdt_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1600000,
  parameter int RST_CYC     = 200000,
  parameter int CLR_CYC     = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic porN,
  input  logic kickIn,
  input  logic manRstN,
  input  logic supplyHi,
  input  logic loopEn,
  output logic sysRstN,
  output logic wdoN
);

  wdtStrobe_t strobe;
  wdtStatus_t status;

  wdt_datapath #(
    .TIMEOUT_CYC(TIMEOUT_CYC), .RST_CYC(RST_CYC),
    .CLR_CYC(CLR_CYC), .SYNC_STAGES(SYNC_STAGES)
  ) i_datapath (
    .clk(clk), .rstN(porN), .kickIn(kickIn), .manRstN(manRstN),
    .strobe(strobe), .status(status)
  );

  wdt_control i_control (
    .clk(clk), .rstN(porN), .loopEn(loopEn), .supplyHi(supplyHi),
    .status(status), .strobe(strobe), .sysRstN(sysRstN), .wdoN(wdoN)
  );

endmodule

// File: tb/test_wdt_supervisor.sv
module test_wdt_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int TO = 20;
  localparam int RC = 12;
  localparam int CC = 3;
  localparam int NVEC = 8;
  // gap after a kick toggle, expected wdoN at end of gap
  localparam int GAP [NVEC] = '{5, 12, 19, 20, 30, 8, 26, 15};
  localparam bit EXPW[NVEC] = '{1, 1, 1, 1, 0, 1, 0, 1};

  logic clk = 1'b0;
  logic porN, kickIn, manRstN, supplyHi, loopEn;
  logic sysRstN, wdoN;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_supervisor #(.TIMEOUT_CYC(TO), .RST_CYC(RC), .CLR_CYC(CC), .SYNC_STAGES(2))
    i_wdt_supervisor (
      .clk(clk), .porN(porN), .kickIn(kickIn), .manRstN(manRstN),
      .supplyHi(supplyHi), .loopEn(loopEn), .sysRstN(sysRstN), .wdoN(wdoN)
    );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggleKick();
    @(negedge clk);
    kickIn = ~kickIn;
  endtask

  // Count cycles until sig reaches val
  task automatic waitSys(input logic val, output int n);
    n = 0;
    while (sysRstN !== val && n < 500) begin @(negedge clk); n++; end
  endtask

  task automatic waitWdo(input logic val, output int n);
    n = 0;
    while (wdoN !== val && n < 500) begin @(negedge clk); n++; end
  endtask

  initial begin
    int n, m, len1, len2, per1, per2;
    porN = 1'b0; kickIn = 1'b0; manRstN = 1'b1; supplyHi = 1'b1; loopEn = 1'b0;
    cyc(3);
    check(sysRstN == 1'b0, "R1 sysRstN in power-on reset", sysRstN, 0);
    check(wdoN == 1'b1, "R1 wdoN in power-on reset", wdoN, 1);
    @(negedge clk); porN = 1'b1;
    waitSys(1'b1, n);
    check(n >= RC && n <= RC + 2, "R1 power-on pulse length", n, RC);

    // Table walk: kick gaps and expected fault level
    for (int i = 0; i < NVEC; i++) begin
      toggleKick();
      cyc(GAP[i]);
      check(wdoN == EXPW[i], EXPW[i] ? "R5 kick in window keeps wdoN high"
                                     : "R4 timeout drops wdoN", wdoN, EXPW[i]);
    end

    // R6: single-cycle kick pulse
    toggleKick();
    cyc(12);
    kickIn = ~kickIn;
    @(negedge clk);
    kickIn = ~kickIn;
    cyc(12);
    check(wdoN == 1'b1, "R6 one-cycle pulse restarts timeout", wdoN, 1);
    cyc(20);
    check(wdoN == 1'b0, "R4 fault after pulse timeout", wdoN, 0);
    check(sysRstN == 1'b1, "R7 no reset without loopback", sysRstN, 1);
    cyc(30);
    check(wdoN == 1'b0, "R7 fault stays latched", wdoN, 0);
    toggleKick();
    waitWdo(1'b1, n);
    check(n <= 5, "R7 kick releases fault", n, 5);

    // R2/R3/R8: long manual reset
    @(negedge clk); manRstN = 1'b0;
    waitSys(1'b0, n);
    check(n <= 4, "R2 manual reset asserts", n, 4);
    cyc(3 * TO);
    check(wdoN == 1'b1, "R3 no fault while reset held", wdoN, 1);
    supplyHi = 1'b0; #1;
    check(wdoN == 1'b0, "R8 wdoN low in reset with supply low", wdoN, 0);
    supplyHi = 1'b1; #1;
    check(wdoN == 1'b1, "R8 wdoN high in reset with supply high", wdoN, 1);
    @(negedge clk); manRstN = 1'b1;
    waitSys(1'b1, n);
    check(n >= RC && n <= RC + 4, "R2 manual pulse length", n, RC);
    waitWdo(1'b0, m);
    check(m >= TO && m <= TO + 5, "R3 timeout restarts at release", m, TO);
    toggleKick();
    cyc(6);

    // R9/R10: loopback with stuck kick
    loopEn = 1'b1;
    waitWdo(1'b0, n);
    waitWdo(1'b1, m);
    check(m >= CC && m <= CC + 3, "R9 wdoN capture pulse width", m, CC);
    check(sysRstN == 1'b0, "R9 reset still active at wdoN return", sysRstN, 0);
    waitSys(1'b1, n);
    waitSys(1'b0, n);
    waitSys(1'b1, len1);
    waitSys(1'b0, n);
    per1 = len1 + n;
    waitSys(1'b1, len2);
    waitSys(1'b0, n);
    per2 = len2 + n;
    check(len1 >= RC && len1 <= RC + CC + 4, "R10 loop reset pulse length", len1, RC);
    check(per1 >= RC + TO && per1 <= RC + TO + CC + 8, "R10 loop reset period", per1, RC + TO);
    check(per1 == per2, "R10 period constant", per2, per1);
    check(len1 == len2, "R10 pulse length constant", len2, len1);

    loopEn = 1'b0;
    cyc(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all-requirements actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule